// File: doc/BRIEF.md
# Saturating Doubling Multiply-Accumulate Lanes

This block is a SIMD datapath stage. It takes two 64-bit source vectors of signed elements and a 128-bit accumulator vector whose elements are twice as wide. Each lane multiplies a pair of source elements and doubles the product. It then adds the doubled product to the matching accumulator element, or subtracts it, and clamps every result to the signed range of the wide element. A size code selects 16-bit elements (four lanes) or 32-bit elements (two lanes). The other size codes are refused and raise an error pulse.

The second source can be used element by element, or one of its elements can be broadcast to every lane. A lane-index input picks that element. The result is registered one cycle after a valid strobe. A sticky flag records that at least one lane saturated. The flag stays set until a synchronous clear input drops it.

Top module: `sdm_mac_lanes`

## Requirements
- R1: With size code 01 (16-bit elements), lane i (0..3) uses bits [16i+15:16i] of both sources and bits [32i+31:32i] of the accumulator. With op 0 it produces acc + 2·a·b in that 32-bit lane position.
- R2: With size code 10 (32-bit elements), lane i (0..1) uses bits [32i+31:32i] of both sources and bits [64i+63:64i] of the accumulator. It produces acc ± 2·a·b in that 64-bit lane position.
- R3: With op 1 the lane produces acc − 2·a·b instead of the sum.
- R4: The doubled product is first clamped to the result width. The only case that overflows is most-negative times most-negative, and it gives the most positive value and counts as saturation.
- R5: The add or subtract step is clamped separately to the most positive or most negative value of the result width, and a clamp counts as saturation.
- R6: When the scalar input is 1, one element of the second source feeds every lane. For 16-bit elements, lane_sel_i[1:0] picks that element. For 32-bit elements, lane_sel_i[0] picks it.
- R7: The result and result_vld_o are registered: they appear one cycle after valid_i is sampled high. result_vld_o is 0 in cycles that follow no accepted operation, and result_o then holds its last value.
- R8: sat_flag_o is set one cycle after an accepted operation in which any lane saturated. It stays set until sat_clr_i is sampled high. If a clear and a saturating operation fall in the same cycle, the flag stays set.
- R9: Size codes 00 and 11 give a size_err_o pulse one cycle later. result_o, result_vld_o and sat_flag_o are left unchanged.
- R10: Reset (rst_n low) clears result_o, result_vld_o, size_err_o and sat_flag_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| sub_i | input | 1 | 0 accumulate, 1 subtract |
| size_i | input | 2 | Element size code: 01 16-bit, 10 32-bit, others illegal |
| scalar_i | input | 1 | Broadcast one element of the second source |
| lane_sel_i | input | 2 | Index of the broadcast element |
| src_a_i | input | 64 | First source vector |
| src_b_i | input | 64 | Second source vector |
| acc_i | input | 128 | Accumulator vector |
| sat_clr_i | input | 1 | Synchronous clear of the saturation flag |
| result_o | output | 128 | Registered result vector |
| result_vld_o | output | 1 | Result valid pulse |
| size_err_o | output | 1 | Illegal size pulse |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
The lanes are swept over a grid of corner values for each element width, operation and operand mode. The grid holds zero, ±1, the most positive value, the most negative value and one above it, and the accumulator lanes are rotated through the same set at double width. This pairs most-negative operands, which isolates the product clamp, with extreme accumulator values, which isolates the add and subtract clamps. Random vectors then check that lanes with ordinary values are computed independently of each other. Hand-worked vectors pin down the lane positions, the broadcast index, the refused size codes and the clear-versus-set ordering of the flag.

// File: rtl/sdm_pkg.sv
`timescale 1ns/1ps
package sdm_pkg;
  // Internal lane width: covers a doubled 32x32 product and a 64-bit sum.
  localparam int WIDE = 66;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_OTHER = 2'b11
  } sdm_size_e;

  typedef struct packed {
    logic            hit;
    logic [WIDE-1:0] val;
  } sdm_clamp_t;

  // Product of two sign-extended elements, doubled.
  function automatic logic signed [WIDE-1:0] dbl_mul(input logic signed [WIDE-1:0] a,
                                                     input logic signed [WIDE-1:0] b);
    return (a * b) <<< 1;
  endfunction

  // Accumulate or subtract step on wide signed values.
  function automatic logic signed [WIDE-1:0] acc_step(input logic signed [WIDE-1:0] acc,
                                                      input logic signed [WIDE-1:0] d,
                                                      input logic sub);
    return sub ? (acc - d) : (acc + d);
  endfunction

  // Clamp into the signed range of rw bits and report whether it clamped.
  function automatic sdm_clamp_t clamp_to(input logic signed [WIDE-1:0] x,
                                          input int unsigned rw);
    logic signed [WIDE-1:0] one, hi, lo;
    sdm_clamp_t r;
    one   = {{(WIDE-1){1'b0}}, 1'b1};
    hi    = (one <<< (rw - 1)) - one;
    lo    = -hi - one;
    r.hit = 1'b0;
    r.val = x;
    if (x > hi) begin
      r.hit = 1'b1;
      r.val = hi;
    end else if (x < lo) begin
      r.hit = 1'b1;
      r.val = lo;
    end
    return r;
  endfunction
endpackage

// File: rtl/sdm_operand_sel.sv
`timescale 1ns/1ps
module sdm_operand_sel #(
  parameter  int VEC_W = 64,
  parameter  int EW    = 16,
  parameter  int SEL_W = 2,
  localparam int N     = VEC_W / EW,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [VEC_W-1:0] b_i,
  input  logic             scalar_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [VEC_W-1:0] b_o
);
  logic [IDX_W-1:0] idx;
  logic [EW-1:0]    pick;

  assign idx  = sel_i[IDX_W-1:0];
  assign pick = b_i[idx*EW +: EW];

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign b_o[g*EW +: EW] = scalar_i ? pick : b_i[g*EW +: EW];
  end

  if (SEL_W > IDX_W) begin : g_spare
    logic sel_unused;
    assign sel_unused = ^sel_i[SEL_W-1:IDX_W];
  end
endmodule

// File: rtl/sdm_lane.sv
`timescale 1ns/1ps
module sdm_lane import sdm_pkg::*; #(
  parameter  int EW = 16,
  localparam int RW = 2 * EW
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [RW-1:0] acc_i,
  input  logic          sub_i,
  output logic [RW-1:0] res_o,
  output logic          mul_sat_o,
  output logic          acc_sat_o
);
  logic signed [WIDE-1:0] a_w, b_w, acc_w, dbl_w;
  sdm_clamp_t dbl_c, out_c;
  logic lane_unused;

  always_comb begin
    a_w   = {{(WIDE-EW){a_i[EW-1]}}, a_i};
    b_w   = {{(WIDE-EW){b_i[EW-1]}}, b_i};
    acc_w = {{(WIDE-RW){acc_i[RW-1]}}, acc_i};
    dbl_w = dbl_mul(a_w, b_w);
    dbl_c = clamp_to(dbl_w, RW);
    out_c = clamp_to(acc_step(acc_w, $signed(dbl_c.val), sub_i), RW);
  end

  assign res_o       = out_c.val[RW-1:0];
  assign mul_sat_o   = dbl_c.hit;
  assign acc_sat_o   = out_c.hit;
  assign lane_unused = ^out_c.val[WIDE-1:RW];
endmodule

// File: rtl/sdm_sticky.sv
`timescale 1ns/1ps
module sdm_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= (flag_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/sdm_mac_lanes.sv
`timescale 1ns/1ps
module sdm_mac_lanes import sdm_pkg::*; #(
  parameter  int VEC_W = 64,
  localparam int ACC_W = 2 * VEC_W,
  localparam int SEL_W = $clog2(VEC_W / 16),
  localparam int NSZ   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             sub_i,
  input  logic [1:0]       size_i,
  input  logic             scalar_i,
  input  logic [SEL_W-1:0] lane_sel_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             sat_clr_i,
  output logic [ACC_W-1:0] result_o,
  output logic             result_vld_o,
  output logic             size_err_o,
  output logic             sat_flag_o
);
  logic [ACC_W-1:0] res_sz [NSZ];
  logic [NSZ-1:0]   mul_sat_sz, acc_sat_sz;

  // One lane array per element size; size index 0 is 16-bit, 1 is 32-bit.
  for (genvar gi = 0; gi < NSZ; gi++) begin : g_size
    localparam int EW = 16 << gi;
    localparam int N  = VEC_W / EW;
    logic [VEC_W-1:0] b_eff;
    logic [ACC_W-1:0] res_v;
    logic [N-1:0]     ms, as;

    sdm_operand_sel #(.VEC_W(VEC_W), .EW(EW), .SEL_W(SEL_W)) u_sel (
      .b_i(src_b_i), .scalar_i(scalar_i), .sel_i(lane_sel_i), .b_o(b_eff)
    );

    for (genvar li = 0; li < N; li++) begin : g_lane
      sdm_lane #(.EW(EW)) u_lane (
        .a_i      (src_a_i[li*EW +: EW]),
        .b_i      (b_eff[li*EW +: EW]),
        .acc_i    (acc_i[li*2*EW +: 2*EW]),
        .sub_i    (sub_i),
        .res_o    (res_v[li*2*EW +: 2*EW]),
        .mul_sat_o(ms[li]),
        .acc_sat_o(as[li])
      );
    end

    assign res_sz[gi]     = res_v;
    assign mul_sat_sz[gi] = |ms;
    assign acc_sat_sz[gi] = |as;
  end

  // Named internal events, also observed by the checker.
  logic             legal, pick_word, accept, mul_sat, acc_sat, any_sat;
  logic [ACC_W-1:0] res_next;

  assign legal     = (size_i == SZ_HALF) || (size_i == SZ_WORD);
  assign pick_word = (size_i == SZ_WORD);
  assign accept    = valid_i & legal;
  assign res_next  = pick_word ? res_sz[1] : res_sz[0];
  assign mul_sat   = pick_word ? mul_sat_sz[1] : mul_sat_sz[0];
  assign acc_sat   = pick_word ? acc_sat_sz[1] : acc_sat_sz[0];
  assign any_sat   = mul_sat | acc_sat;

  sdm_sticky u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(accept & any_sat), .clr_i(sat_clr_i), .flag_o(sat_flag_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o     <= '0;
      result_vld_o <= 1'b0;
      size_err_o   <= 1'b0;
    end else begin
      result_vld_o <= accept;
      size_err_o   <= valid_i & ~legal;
      if (accept) result_o <= res_next;
    end
  end
endmodule

// File: rtl/sdm_mac_lanes_chk.sv
`timescale 1ns/1ps
module sdm_mac_lanes_chk #(
  parameter int ACC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic             sat_clr_i,
  input logic             legal,
  input logic             mul_sat,
  input logic             any_sat,
  input logic [ACC_W-1:0] result_o,
  input logic             result_vld_o,
  input logic             size_err_o,
  input logic             sat_flag_o
);
  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |=> (!result_vld_o && !size_err_o && !sat_flag_o && result_o == '0));

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && legal) |=> (result_vld_o && !size_err_o));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!result_vld_o && !size_err_o && $stable(result_o)));

  assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !legal && !sat_clr_i) |=>
      (size_err_o && !result_vld_o && $stable(result_o) && $stable(sat_flag_o)));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag_o && !sat_clr_i) |=> sat_flag_o);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && legal && any_sat) |=> sat_flag_o);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr_i && !(valid_i && legal && any_sat)) |=> !sat_flag_o);

  assert_product_clamp_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && legal && mul_sat) |=> (sat_flag_o && result_vld_o));
endmodule

bind sdm_mac_lanes sdm_mac_lanes_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sat_clr_i(sat_clr_i),
  .legal(legal), .mul_sat(mul_sat), .any_sat(any_sat),
  .result_o(result_o), .result_vld_o(result_vld_o),
  .size_err_o(size_err_o), .sat_flag_o(sat_flag_o)
);

// File: tb/sdm_mac_lanes_test.sv
`timescale 1ns/1ps
module sdm_mac_lanes_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, sub_i = 1'b0, scalar_i = 1'b0, sat_clr_i = 1'b0;
  logic [1:0] size_i = 2'b01, lane_sel_i = 2'b00;
  logic [63:0] src_a_i = '0, src_b_i = '0;
  logic [127:0] acc_i = '0;
  logic [127:0] result_o;
  logic result_vld_o, size_err_o, sat_flag_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [127:0] exp_res = '0;
  bit exp_flag = 1'b0;

  always #2 clk = ~clk;

  sdm_mac_lanes uut (.*);

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [71:0] sx(input logic [127:0] x, input int w);
    logic signed [71:0] r;
    for (int k = 0; k < 72; k++) r[k] = (k < w) ? x[k] : x[w-1];
    return r;
  endfunction

  // Value k of the corner set {0, 1, -1, max, min, min+1} at width w.
  function automatic logic [63:0] corner(input int k, input int w);
    logic [63:0] one = 64'd1, mask, v;
    mask = (w == 64) ? '1 : ((one << w) - 1);
    case (k)
      0: v = 0;
      1: v = 1;
      2: v = '1;
      3: v = (one << (w - 1)) - 1;
      4: v = one << (w - 1);
      default: v = (one << (w - 1)) + 1;
    endcase
    return v & mask;
  endfunction

  function automatic logic [127:0] put(input logic [127:0] vec, input int idx, input int w, input logic [63:0] val);
    for (int k = 0; k < w; k++) vec[idx*w + k] = val[k];
    return vec;
  endfunction

  // Arithmetic model from the requirements: wide signed math, explicit clamps.
  task automatic ref_model(input bit sub, input bit w32, input bit scal, input logic [1:0] sel,
                           input logic [63:0] a, input logic [63:0] b, input logic [127:0] acc,
                           output logic [127:0] res, output bit sat);
    int w, n, bi;
    logic signed [71:0] ea, eb, ec, d, s, hi, lo;
    w = w32 ? 32 : 16;
    n = 64 / w;
    res = '0;
    sat = 1'b0;
    hi = (72'sd1 <<< (2*w - 1)) - 72'sd1;
    lo = -hi - 72'sd1;
    for (int i = 0; i < n; i++) begin
      bi = scal ? (w32 ? int'(sel[0]) : int'(sel)) : i;
      ea = sx(128'(a) >> (i*w), w);
      eb = sx(128'(b) >> (bi*w), w);
      ec = sx(acc >> (i*2*w), 2*w);
      d = ea * eb * 72'sd2;
      if (d > hi) begin d = hi; sat = 1'b1; end
      s = sub ? ec - d : ec + d;
      if (s > hi) begin s = hi; sat = 1'b1; end
      if (s < lo) begin s = lo; sat = 1'b1; end
      for (int k = 0; k < 2*w; k++) res[i*2*w + k] = s[k];
    end
  endtask

  task automatic run_op(input string tag, input bit sub, input logic [1:0] sz, input bit scal,
                        input logic [1:0] sel, input logic [63:0] a, input logic [63:0] b,
                        input logic [127:0] acc, input bit clr);
    logic [127:0] r;
    bit s, lg;
    lg = (sz == 2'b01) || (sz == 2'b10);
    ref_model(sub, sz == 2'b10, scal, sel, a, b, acc, r, s);
    valid_i = 1'b1; sub_i = sub; size_i = sz; scalar_i = scal; lane_sel_i = sel;
    src_a_i = a; src_b_i = b; acc_i = acc; sat_clr_i = clr;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0; sat_clr_i = 1'b0;
    if (clr) exp_flag = 1'b0;
    if (lg && s) exp_flag = 1'b1;
    if (lg) exp_res = r;
    chk(tag, "result", result_o, exp_res);
    chk(tag, "valid", 128'(result_vld_o), 128'(lg));
    chk(tag, "size error", 128'(size_err_o), 128'(!lg));
    chk(tag, "flag", 128'(sat_flag_o), 128'(exp_flag));
  endtask

  task automatic idle(input string tag, input bit clr);
    sat_clr_i = clr;
    @(posedge clk);
    @(negedge clk);
    sat_clr_i = 1'b0;
    if (clr) exp_flag = 1'b0;
    chk(tag, "idle valid", 128'(result_vld_o), 128'(0));
    chk(tag, "idle error", 128'(size_err_o), 128'(0));
    chk(tag, "idle result", result_o, exp_res);
    chk(tag, "idle flag", 128'(sat_flag_o), 128'(exp_flag));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs cleared during reset
    chk("R10", "reset result", result_o, '0);
    chk("R10", "reset valid", 128'(result_vld_o), 128'(0));
    chk("R10", "reset error", 128'(size_err_o), 128'(0));
    chk("R10", "reset flag", 128'(sat_flag_o), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1: hand-worked 16-bit accumulate
    run_op("R1", 0, 2'b01, 0, 0, 64'h0007_0000_FFFD_0002, 64'hFFFF_0005_0004_0003,
           {32'd100, 32'hFFFF_FFFB, 32'd0, 32'd10}, 0);
    chk("R1", "hand", result_o, {32'd86, 32'hFFFF_FFFB, 32'hFFFF_FFE8, 32'd22});
    // R7: no operation, result held
    idle("R7", 0);

    // R4: most negative squared clamps the doubled product
    run_op("R4", 0, 2'b01, 0, 0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, '0, 0);
    chk("R4", "hand", result_o, 128'h0000_0000_0000_0000_0000_0000_7FFF_FFFF);
    chk("R4", "flag", 128'(sat_flag_o), 128'(1));

    // R9: illegal sizes leave state alone
    run_op("R9", 0, 2'b00, 0, 0, 64'h1234, 64'h5678, 128'h9, 0);
    run_op("R9", 1, 2'b11, 0, 0, 64'h8000, 64'h8000, 128'h0, 0);

    // R8: clear drops the flag
    idle("R8", 1);
    chk("R8", "flag cleared", 128'(sat_flag_o), 128'(0));

    // R5: 32-bit subtract step clamps to the most negative
    run_op("R5", 1, 2'b10, 0, 0, 64'h1, 64'h7FFF_FFFF, {64'd0, 64'h8000_0000_0000_0000}, 0);
    chk("R5", "hand", result_o, {64'd0, 64'h8000_0000_0000_0000});
    chk("R5", "flag", 128'(sat_flag_o), 128'(1));

    // R8: clear and saturation together keeps the flag set
    run_op("R8", 0, 2'b01, 0, 0, 64'h8000, 64'h8000, '0, 1);
    chk("R8", "set wins", 128'(sat_flag_o), 128'(1));
    idle("R8", 1);

    // R6: broadcast element 2 of the second source
    run_op("R6", 0, 2'b01, 1, 2'd2, 64'h0001_0001_0001_0001, 64'h0009_0005_0009_0009, '0, 0);
    chk("R6", "hand", result_o, {32'd10, 32'd10, 32'd10, 32'd10});
    run_op("R6", 0, 2'b10, 1, 2'd1, 64'h0000_0003_0000_0002, 64'h0000_0007_0000_0001, '0, 0);
    chk("R6", "hand32", result_o, {64'd42, 64'd28});

    // Corner sweep: R1, R2, R3, R4, R5, R6
    for (int sz = 1; sz <= 2; sz++)
      for (int sub = 0; sub < 2; sub++)
        for (int scal = 0; scal < 2; scal++)
          for (int ai = 0; ai < 6; ai++)
            for (int bi = 0; bi < 6; bi++) begin
              int w, n;
              logic [127:0] a, b, acc;
              string tag;
              w = 16 * sz; n = 64 / w;
              a = '0; b = '0; acc = '0;
              for (int l = 0; l < n; l++) begin
                a   = put(a, l, w, corner((ai + l) % 6, w));
                b   = put(b, l, w, corner((bi + 2*l) % 6, w));
                acc = put(acc, l, 2*w, corner((ai + bi + l) % 6, 2*w));
              end
              tag = scal ? "R6" : (sub ? "R3" : (sz == 1 ? "R1" : "R2"));
              run_op(tag, sub[0], 2'(sz), scal[0], 2'(bi % 4), a[63:0], b[63:0], acc,
                     (ai == 0) && (bi == 0));
            end

    // Random vectors: R1, R2, R3
    for (int t = 0; t < 300; t++) begin
      logic [63:0] a, b;
      logic [127:0] acc;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      acc = {$urandom, $urandom, $urandom, $urandom};
      run_op((t % 2) ? "R2" : "R1", t[2], (t % 2) ? 2'b10 : 2'b01, t[3], 2'(t), a, b, acc, t[4]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule